// File: doc/BRIEF.md
# Programmable Timer Interrupt Counter

This block is a down-counting interval timer clocked by the CPU clock. Software loads a reload value through byte-wide write strobes and then writes a control word. When the control word has its enable bit set, the counter is loaded from the reload value and counts down once per cycle. When it reaches zero, the timer raises its interrupt and loads itself again from the reload value. It then either stops (one-shot) or keeps running (repeat).

The interrupt is a level held in a pending flag. The same flag is the bit returned in position 0 of the status register. The flag is cleared in three ways: a status read strobe, a control write with the enable bit clear, or the master I/O enable input going low. The master enable gates the control register but not the reload bytes. The chip's address decoder supplies the write and read strobes.

Top module: `tmr_irq_unit`

## Requirements
- R1: After reset, `irq_o` and `pend_o` are 0, the counter is stopped, and the enable and repeat flags are clear.
- R2: The reload value is built from `rld_wr_stb` lanes: lane 0 writes bits 7:0 and lane 1 writes bits 15:8 from `wr_data`. A control write with `wr_data` bit 1 (enable) set loads the counter from the reload value. With reload N, the interrupt appears N+2 cycles after the cycle of the control strobe.
- R3: With `wr_data` bit 0 (repeat) clear in the control write, the timer fires once and then clears its enable, so no further interrupt follows.
- R4: With repeat set, the timer fires every N+1 cycles for as long as it stays enabled.
- R5: A reload value of 0 gives an interrupt on the cycle right after the counter is loaded. With repeat also set, the timer fires on every cycle.
- R6: Reload byte writes take effect while `io_en` is low. Control writes while `io_en` is low are ignored: they neither load nor start the counter.
- R7: While `io_en` is low, the counter is stopped and the pending interrupt is cleared on the next cycle.
- R8: A control write with bit 1 clear stops the counter and clears the pending interrupt on the next cycle.
- R9: A status read strobe clears the pending interrupt on the next cycle. If the timer fires in the same cycle as the read, the firing wins and the interrupt stays set.
- R10: `irq_o` is active high and level-sensitive. It stays high from the firing until an acknowledge takes effect, and `pend_o` always reports the same flag.
- R11: A reload write while the counter runs does not change the count in progress. The new value is used at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| io_en | input | 1 | Master disk-I/O enable level |
| rld_wr_stb | input | CNT_W/DATA_W | Reload byte write strobes, lane 0 is the low byte |
| ctl_wr_stb | input | 1 | Control register write strobe |
| stat_rd_stb | input | 1 | Status register read strobe |
| wr_data | input | DATA_W | Write data for reload bytes and control |
| irq_o | output | 1 | Timer interrupt request, level, active high |
| pend_o | output | 1 | Pending flag returned in status bit 0 |

## Verification
The hardest condition to reach is a status read that lands in the same cycle as a firing. A read does not stop the timer, so a normal interval timer only offers that coincidence in a narrow window. The stimulus programs a reload of zero with repeat set, which makes the timer fire on every cycle, and then issues back-to-back status reads. The interrupt must stay high through all of them. A second difficult case is proving that a reload byte was stored while the master enable was low. To show it, the bench later enables the block and checks that the firing time matches the stored value and not the old one.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    // Control word field positions
    localparam int CTL_RPT_BIT = 0;
    localparam int CTL_EN_BIT  = 1;
endpackage

// File: rtl/tmr_reload_regs.sv
module tmr_reload_regs #(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 8,
    localparam int LANES = CNT_W / DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LANES-1:0]  wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CNT_W-1:0]  reload_o
);
    logic [CNT_W-1:0] rld_d, rld_q;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_comb begin
            rld_d[l*DATA_W +: DATA_W] = rld_q[l*DATA_W +: DATA_W];
            if (wr_stb[l]) begin
                rld_d[l*DATA_W +: DATA_W] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rld_q <= '0;
        end else begin
            rld_q <= rld_d;
        end
    end

    assign reload_o = rld_q;
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             io_en,
    input  logic             ctl_wr,
    input  logic             ctl_en,
    input  logic             ctl_rpt,
    input  logic [CNT_W-1:0] reload,
    output logic             fire_o,
    output logic             kill_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             en;
        logic             rpt;
    } core_t;

    core_t st_d, st_q;
    logic  fire_d, kill_d;

    always_comb begin
        st_d   = st_q;
        fire_d = 1'b0;
        kill_d = 1'b0;
        if (!io_en) begin
            st_d.en = 1'b0;
            kill_d  = 1'b1;
        end else if (ctl_wr) begin
            st_d.en  = ctl_en;
            st_d.rpt = ctl_rpt;
            if (ctl_en) begin
                st_d.cnt = reload;
            end else begin
                kill_d = 1'b1;
            end
        end else if (st_q.en) begin
            if (st_q.cnt == '0) begin
                fire_d   = 1'b1;
                st_d.cnt = reload;
                st_d.en  = st_q.rpt;
            end else begin
                st_d.cnt = st_q.cnt - ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fire_o = fire_d;
    assign kill_o = kill_d;
endmodule

// File: rtl/tmr_pending_flag.sv
module tmr_pending_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);
    logic pend_d, pend_q;

    always_comb begin
        pend_d = pend_q;
        if (set_i) begin
            pend_d = 1'b1;
        end else if (clr_i) begin
            pend_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= pend_d;
        end
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/tmr_irq_unit.sv
module tmr_irq_unit #(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 8,
    localparam int LANES = CNT_W / DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_en,
    input  logic [LANES-1:0]  rld_wr_stb,
    input  logic              ctl_wr_stb,
    input  logic              stat_rd_stb,
    input  logic [DATA_W-1:0] wr_data,
    output logic              irq_o,
    output logic              pend_o
);
    import tmr_pkg::*;

    logic [CNT_W-1:0] reload_w;
    logic             fire_w;
    logic             kill_w;
    logic             pend_w;

    tmr_reload_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_rld (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb   (rld_wr_stb),
        .wr_data  (wr_data),
        .reload_o (reload_w)
    );

    tmr_count_core #(.CNT_W(CNT_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .io_en   (io_en),
        .ctl_wr  (ctl_wr_stb),
        .ctl_en  (wr_data[CTL_EN_BIT]),
        .ctl_rpt (wr_data[CTL_RPT_BIT]),
        .reload  (reload_w),
        .fire_o  (fire_w),
        .kill_o  (kill_w)
    );

    tmr_pending_flag u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (fire_w),
        .clr_i  (kill_w | stat_rd_stb),
        .pend_o (pend_w)
    );

    assign irq_o  = pend_w;
    assign pend_o = pend_w;
endmodule

// File: rtl/tmr_irq_chk.sv
module tmr_irq_chk (
    input logic clk,
    input logic rst_n,
    input logic io_en,
    input logic ctl_wr_stb,
    input logic ctl_en_bit,
    input logic stat_rd_stb,
    input logic fire,
    input logic irq_o
);
    // Read acknowledge when no firing coincides
    assert_read_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (io_en && stat_rd_stb && !fire) |=> !irq_o);

    // Firing always raises the level
    assert_fire_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> irq_o);

    // Level is held while no acknowledge happens
    assert_level_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && io_en && !stat_rd_stb && !(ctl_wr_stb && !ctl_en_bit)) |=> irq_o);

    // Master enable low clears pending
    assert_master_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !io_en |=> !irq_o);

    // Control write with enable clear acknowledges
    assert_stop_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (io_en && ctl_wr_stb && !ctl_en_bit) |=> !irq_o);

    // No rise without master enable in the prior cycle
    assert_rise_needs_io_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(io_en));
endmodule

bind tmr_irq_unit tmr_irq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .io_en       (io_en),
    .ctl_wr_stb  (ctl_wr_stb),
    .ctl_en_bit  (wr_data[1]),
    .stat_rd_stb (stat_rd_stb),
    .fire        (fire_w),
    .irq_o       (irq_o)
);

// File: tb/sim_tmr_irq_unit.sv
`timescale 1ns/1ps
module sim_tmr_irq_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       io_en = 1'b0;
    logic [1:0] rld_wr_stb = '0;
    logic       ctl_wr_stb = 1'b0;
    logic       stat_rd_stb = 1'b0;
    logic [7:0] wr_data = '0;
    logic       irq_o;
    logic       pend_o;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;
    bit done = 1'b0;

    int    q_cyc[$];
    bit    q_val[$];
    string q_tag[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    tmr_irq_unit u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .io_en       (io_en),
        .rld_wr_stb  (rld_wr_stb),
        .ctl_wr_stb  (ctl_wr_stb),
        .stat_rd_stb (stat_rd_stb),
        .wr_data     (wr_data),
        .irq_o       (irq_o),
        .pend_o      (pend_o)
    );

    // Monitor: pop expected items when their cycle arrives
    always @(negedge clk) begin
        while (q_cyc.size() > 0 && q_cyc[0] <= cyc) begin
            int    c;
            bit    v;
            string t;
            c = q_cyc.pop_front();
            v = q_val.pop_front();
            t = q_tag.pop_front();
            compared++;
            if (irq_o !== v || pend_o !== v) begin
                mismatched++;
                $display("FAIL %s cycle %0d: irq=%b pend=%b expected %b",
                         t, c, irq_o, pend_o, v);
            end
        end
    end

    task automatic expect_at(int c, bit v, string tag);
        q_cyc.push_back(c);
        q_val.push_back(v);
        q_tag.push_back(tag);
    endtask

    task automatic wait_until(int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic wr_rld(int lane, logic [7:0] v);
        rld_wr_stb[lane] = 1'b1;
        wr_data = v;
        @(negedge clk);
        rld_wr_stb = '0;
    endtask

    task automatic wr_ctl(logic [7:0] v);
        ctl_wr_stb = 1'b1;
        wr_data = v;
        @(negedge clk);
        ctl_wr_stb = 1'b0;
    endtask

    task automatic rd_stat();
        stat_rd_stb = 1'b1;
        @(negedge clk);
        stat_rd_stb = 1'b0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog (all requirements): run did not end, expected completion");
            finish_run();
        end
    end

    initial begin
        int t;
        repeat (3) @(negedge clk);
        // R1: reset state
        if (irq_o !== 1'b0 || pend_o !== 1'b0) begin
            mismatched++;
            $display("FAIL R1 in reset: irq=%b pend=%b expected 0", irq_o, pend_o);
        end
        compared++;
        rst_n = 1'b1;
        t = cyc;
        expect_at(t + 1, 1'b0, "R1");
        expect_at(t + 2, 1'b0, "R1");
        wait_until(t + 3);

        // R2 / R3: one-shot, reload 5
        io_en = 1'b1;
        wr_rld(0, 8'd5);
        wr_rld(1, 8'd0);
        t = cyc;
        expect_at(t + 6, 1'b0, "R2");
        expect_at(t + 7, 1'b1, "R2");
        wr_ctl(8'h02);
        wait_until(t + 10);
        expect_at(t + 11, 1'b1, "R10");
        expect_at(t + 12, 1'b1, "R9");
        expect_at(t + 13, 1'b0, "R9");
        expect_at(t + 20, 1'b0, "R3");
        expect_at(t + 40, 1'b0, "R3");
        wait_until(t + 12);
        rd_stat();
        wait_until(t + 41);

        // R4 / R11 / R8: repeat with reload 3, then reload 6
        wr_rld(0, 8'd3);
        t = cyc;
        expect_at(t + 4,  1'b0, "R4");
        expect_at(t + 5,  1'b1, "R4");
        expect_at(t + 6,  1'b0, "R4");
        expect_at(t + 8,  1'b0, "R4");
        expect_at(t + 9,  1'b1, "R4");
        expect_at(t + 10, 1'b0, "R4");
        wr_ctl(8'h03);
        wait_until(t + 5);
        rd_stat();
        wait_until(t + 9);
        rd_stat();
        wr_rld(0, 8'd6);
        expect_at(t + 13, 1'b1, "R11");
        expect_at(t + 14, 1'b0, "R11");
        expect_at(t + 19, 1'b0, "R11");
        expect_at(t + 20, 1'b1, "R11");
        expect_at(t + 21, 1'b0, "R8");
        expect_at(t + 30, 1'b0, "R8");
        wait_until(t + 13);
        rd_stat();
        wait_until(t + 20);
        wr_ctl(8'h00);
        wait_until(t + 31);

        // R5 / R9 / R7: reload zero
        wr_rld(0, 8'd0);
        t = cyc;
        expect_at(t + 1, 1'b0, "R5");
        expect_at(t + 2, 1'b1, "R5");
        wr_ctl(8'h02);
        wait_until(t + 3);
        expect_at(t + 4, 1'b0, "R5");
        expect_at(t + 8, 1'b0, "R5");
        rd_stat();
        wait_until(t + 10);
        expect_at(t + 12, 1'b1, "R5");
        expect_at(t + 13, 1'b1, "R9");
        expect_at(t + 14, 1'b1, "R9");
        expect_at(t + 15, 1'b1, "R9");
        expect_at(t + 17, 1'b0, "R7");
        expect_at(t + 25, 1'b0, "R7");
        wr_ctl(8'h03);
        wait_until(t + 12);
        rd_stat();
        rd_stat();
        rd_stat();
        wait_until(t + 16);
        io_en = 1'b0;
        wait_until(t + 26);

        // R6: reload write while disabled, control write ignored
        t = cyc;
        expect_at(t + 8, 1'b0, "R6");
        wr_rld(0, 8'd2);
        wr_ctl(8'h02);
        wait_until(t + 12);
        io_en = 1'b1;
        expect_at(t + 15, 1'b0, "R6");
        expect_at(t + 16, 1'b0, "R6");
        expect_at(t + 17, 1'b1, "R6");
        expect_at(t + 19, 1'b1, "R7");
        expect_at(t + 20, 1'b0, "R7");
        wait_until(t + 13);
        wr_ctl(8'h02);
        wait_until(t + 19);
        io_en = 1'b0;
        wait_until(t + 23);

        done = 1'b1;
        finish_run();
    end
endmodule